// File: doc/BRIEF.md
# Keyed Watchdog Reset Timer

This block guards a small microcontroller core against runaway software. A count chain made of a prescaler and an 8-bit reload counter advances once per machine cycle, marked by a tick input. If software lets the reload counter roll over from its all-ones value to zero, the block raises a reset request that lasts one machine cycle.

Software works the block through a simple special-function-register write port. A write to the reload address is accepted only while the load-enable bit from the power-control register is set. The first accepted load starts the timer. Every accepted load clears the prescaler and tells the power-control register to drop the enable, so each reload needs a fresh enable. A key value written to the key address stops the timer, and so does a hardware reset. After a reset request the timer stays stopped until software loads it again. The timeout is (256 - V) x 2^PRE_W machine cycles, where V is the value loaded.

Top module: `wdog_timer`

## Requirements
- R1: After reset both `rst_req` and `load_en_clr` are low, and the timer raises no request until it has been loaded.
- R2: A write to address FFh while `load_en` is 0 is ignored: it starts no timer and pulses no `load_en_clr`.
- R3: A write of value V to address FFh while `load_en` is 1 starts the timer. `rst_req` rises after the clock edge of the (256 - V) x 2^PRE_W-th tick that follows the load edge. A tick on the load edge itself is not counted.
- R4: An accepted reload while the timer runs discards the progress so far, prescaler included, and the full interval for the new value begins at the load edge.
- R5: `rst_req` stays high from the overflow edge up to and including the next tick edge, which is one machine cycle.
- R6: After a request the timer is stopped. No further request comes until software loads it again.
- R7: Writing 55h to address FEh stops the timer, and no request follows. Any other value written to FEh has no effect on the timeout.
- R8: Asserting `rst_n` while the timer runs stops it, and no request follows after reset is released.
- R9: `load_en_clr` is high for exactly the one clock after each accepted load and is low otherwise.
- R10: When an accepted reload or a 55h key write falls on the clock edge of the overflowing tick, the write wins and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mc_tick | input | 1 | One-clock strobe, once per machine cycle |
| load_en | input | 1 | Load-enable bit from the power-control register |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address (FEh key, FFh reload) |
| sfr_wdata | input | 8 | Register write data |
| load_en_clr | output | 1 | One-clock request to clear the load-enable bit |
| rst_req | output | 1 | Reset request to the core, one machine cycle long |

## Verification
Two functions can land on the same clock edge: a software write, either a reload or the stop key, and the tick that carries the chain over from all ones. The bench counts ticks after a load. It places an accepted reload, and in a separate run a 55h key write, on the exact clock whose tick is the overflowing one. It then requires that no request appears on that edge. After the reload case the request must come exactly one full interval later, and after the key case it must never come.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned SFR_AW = 8;
  localparam int unsigned SFR_DW = 8;

  localparam logic [SFR_AW-1:0] ADDR_KEY  = 8'hFE;
  localparam logic [SFR_AW-1:0] ADDR_LOAD = 8'hFF;
  localparam logic [SFR_DW-1:0] STOP_KEY  = 8'h55;

  typedef struct packed {
    logic load;
    logic stop;
  } wd_cmd_t;

endpackage

// File: rtl/wdog_sfr_dec.sv
module wdog_sfr_dec
  import wdog_pkg::*;
(
  input  logic              sfr_wr,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [SFR_DW-1:0] sfr_wdata,
  input  logic              load_en,
  output wd_cmd_t           cmd
);

  always_comb begin
    cmd.load = sfr_wr && (sfr_addr == ADDR_LOAD) && load_en;
    cmd.stop = sfr_wr && (sfr_addr == ADDR_KEY) && (sfr_wdata == STOP_KEY);
  end

endmodule

// File: rtl/wdog_chain.sv
module wdog_chain #(
  parameter int unsigned PRE_W = 11,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             adv,
  output logic             wrap
);

  localparam logic [PRE_W-1:0] PRE_ZERO = '0;
  localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pre_en, cnt_en;
  logic             pre_carry;

  assign pre_carry = &pre_q;
  assign wrap      = adv && pre_carry && (&cnt_q);

  always_comb begin
    pre_en = load || adv;
    cnt_en = load || (adv && pre_carry);
    pre_d  = load ? PRE_ZERO : pre_q + PRE_ONE;
    cnt_d  = load ? load_val : cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (pre_en) pre_q <= pre_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pre_q == PRE_ZERO) && (cnt_q == $past(load_val))); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> ($stable(pre_q) && $stable(cnt_q))); // R3

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic stop,
  input  logic wrap,
  input  logic mc_tick,
  output logic run,
  output logic rst_req,
  output logic load_en_clr
);

  logic run_q, run_d;
  logic req_q, req_d;
  logic clr_q;
  logic fire;

  assign fire = wrap && !load && !stop;

  always_comb begin
    run_d = run_q;
    if (fire || stop) run_d = 1'b0;
    if (load)         run_d = 1'b1;
    req_d = req_q;
    if (mc_tick) req_d = 1'b0;
    if (fire)    req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      req_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      run_q <= run_d;
      req_q <= req_d;
      clr_q <= load;
    end
  end

  assign run         = run_q;
  assign rst_req     = req_q;
  assign load_en_clr = clr_q;

  AST_KEY_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !run_q); // R7

  AST_FIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!run_q && req_q)); // R6

  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && mc_tick) |=> !req_q); // R5

  AST_CLR_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> clr_q); // R9

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned PRE_W = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              load_en,
  input  logic              sfr_wr,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [SFR_DW-1:0] sfr_wdata,
  output logic              load_en_clr,
  output logic              rst_req
);

  localparam int unsigned CNT_W = SFR_DW;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  wd_cmd_t                cmd;
  logic                   run;
  logic                   wrap;
  logic                   adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_int_n = rst_pipe[SYNC_STAGES-1];
  assign adv       = run && mc_tick;

  wdog_sfr_dec u_dec (
    .sfr_wr    (sfr_wr),
    .sfr_addr  (sfr_addr),
    .sfr_wdata (sfr_wdata),
    .load_en   (load_en),
    .cmd       (cmd)
  );

  wdog_chain #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (cmd.load),
    .load_val (sfr_wdata),
    .adv      (adv),
    .wrap     (wrap)
  );

  wdog_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .load        (cmd.load),
    .stop        (cmd.stop),
    .wrap        (wrap),
    .mc_tick     (mc_tick),
    .run         (run),
    .rst_req     (rst_req),
    .load_en_clr (load_en_clr)
  );

  AST_NO_FIRE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_req) |-> (!$past(cmd.load) && !$past(cmd.stop))); // R10

  AST_FIRE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_req) |-> $past(run)); // R1

endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int TB_PRE     = 3;
  localparam int TICK_DIV   = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mc_tick;
  logic       load_en;
  logic       sfr_wr;
  logic [7:0] sfr_addr;
  logic [7:0] sfr_wdata;
  logic       load_en_clr;
  logic       rst_req;

  int checks = 0;
  int fails  = 0;
  int phase  = 0;
  logic last_tick, o_req, o_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.PRE_W(TB_PRE)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mc_tick     (mc_tick),
    .load_en     (load_en),
    .sfr_wr      (sfr_wr),
    .sfr_addr    (sfr_addr),
    .sfr_wdata   (sfr_wdata),
    .load_en_clr (load_en_clr),
    .rst_req     (rst_req)
  );

  function automatic int exp_ticks(input int v);
    return (256 - v) * (1 << TB_PRE);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    last_tick = mc_tick;
    o_req     = rst_req;
    o_clr     = load_en_clr;
    mc_tick   = (phase == TICK_DIV - 1);
    phase     = (phase == TICK_DIV - 1) ? 0 : phase + 1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic en);
    load_en = en; sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    cyc();
    sfr_wr = 1'b0; load_en = 1'b0;
  endtask

  // counts ticks after the last write until rst_req is seen; -1 if none
  task automatic wait_fire(input int max_ticks, output int got);
    int t = 0;
    got = -1;
    while (t <= max_ticks) begin
      cyc();
      if (last_tick) t++;
      if (o_req) begin got = t; break; end
    end
  endtask

  task automatic pulse_width(output int w);
    w = 1;
    for (int k = 0; k < 50; k++) begin
      cyc();
      if (!o_req) break;
      w++;
    end
  endtask

  task automatic run_to(input int n);
    int t = 0;
    while (t < n) begin
      cyc();
      if (last_tick) t++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int got, w, v;
    void'($urandom(1234));
    mc_tick = 0; load_en = 0; sfr_wr = 0; sfr_addr = 0; sfr_wdata = 0;
    do_reset();

    // R1 reset state
    chk(o_req == 0, "R1 rst_req", o_req, 0);
    chk(o_clr == 0, "R1 load_en_clr", o_clr, 0);
    wait_fire(3000, got);
    chk(got == -1, "R1 no request before load", got, -1);

    // R2 disabled write ignored
    wr(8'hFF, 8'hFF, 1'b0);
    chk(o_clr == 0, "R2 no clr", o_clr, 0);
    wait_fire(100, got);
    chk(got == -1, "R2 disabled load ignored", got, -1);

    // R3, R9, R5, R6 basic load
    wr(8'hFF, 8'hFF, 1'b1);
    chk(o_clr == 1, "R9 clr after load", o_clr, 1);
    cyc();
    chk(o_clr == 0, "R9 clr one clock", o_clr, 0);
    wait_fire(200, got);
    chk(got == exp_ticks(255) - 0, "R3 timeout FFh", got, exp_ticks(255));
    pulse_width(w);
    chk(w == TICK_DIV, "R5 pulse width", w, TICK_DIV);
    wait_fire(300, got);
    chk(got == -1, "R6 stays stopped", got, -1);

    // R3 random loads
    for (int i = 0; i < 8; i++) begin
      v = 192 + ($urandom % 64);
      wr(8'hFF, v[7:0], 1'b1);
      chk(o_clr == 1, "R9 clr random load", o_clr, 1);
      wait_fire(exp_ticks(v) + 10, got);
      chk(got == exp_ticks(v), "R3 random timeout", got, exp_ticks(v));
      pulse_width(w);
    end

    // R3 longest interval, 00h
    wr(8'hFF, 8'h00, 1'b1);
    wait_fire(exp_ticks(0) + 10, got);
    chk(got == exp_ticks(0), "R3 timeout 00h", got, exp_ticks(0));
    pulse_width(w);

    // R4 reload mid-run, prescaler mid-count
    wr(8'hFF, 8'hF0, 1'b1);
    run_to(53);
    wr(8'hFF, 8'hF0, 1'b1);
    wait_fire(400, got);
    chk(got == exp_ticks(8'hF0), "R4 reload restarts", got, exp_ticks(8'hF0));
    pulse_width(w);

    // R2 disabled reload while running has no effect
    wr(8'hFF, 8'hFE, 1'b1);
    run_to(5);
    wr(8'hFF, 8'h00, 1'b0);
    wait_fire(100, got);
    chk(got == exp_ticks(8'hFE) - 5, "R2 disabled reload ignored", got, exp_ticks(8'hFE) - 5);
    pulse_width(w);

    // R7 key stops
    wr(8'hFF, 8'hFE, 1'b1);
    run_to(5);
    wr(8'hFE, 8'h55, 1'b0);
    wait_fire(400, got);
    chk(got == -1, "R7 key stops", got, -1);

    // R7 wrong key ignored
    wr(8'hFF, 8'hFE, 1'b1);
    run_to(3);
    wr(8'hFE, 8'hAA, 1'b0);
    wait_fire(100, got);
    chk(got == exp_ticks(8'hFE) - 3, "R7 wrong key ignored", got, exp_ticks(8'hFE) - 3);
    pulse_width(w);

    // R10 reload on overflow edge
    wr(8'hFF, 8'hFF, 1'b1);
    begin
      int t = 0;
      while (!(t == exp_ticks(255) - 1 && mc_tick)) begin
        cyc(); if (last_tick) t++;
      end
    end
    wr(8'hFF, 8'hFF, 1'b1);
    chk(o_req == 0, "R10 reload beats overflow", o_req, 0);
    wait_fire(200, got);
    chk(got == exp_ticks(255), "R10 interval after collision", got, exp_ticks(255));
    pulse_width(w);

    // R10 key on overflow edge
    wr(8'hFF, 8'hFF, 1'b1);
    begin
      int t = 0;
      while (!(t == exp_ticks(255) - 1 && mc_tick)) begin
        cyc(); if (last_tick) t++;
      end
    end
    wr(8'hFE, 8'h55, 1'b0);
    chk(o_req == 0, "R10 key beats overflow", o_req, 0);
    wait_fire(200, got);
    chk(got == -1, "R10 stopped after key collision", got, -1);

    // R8 hardware reset stops
    wr(8'hFF, 8'hF0, 1'b1);
    run_to(20);
    do_reset();
    chk(o_req == 0 && o_clr == 0, "R8 outputs after reset", o_req, 0);
    wait_fire(400, got);
    chk(got == -1, "R8 reset stops timer", got, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule